// File: doc/BRIEF.md
# Return-Address Hash Engine

This block produces a 64-bit keyed signature from two 64-bit operands (`ra_i`, `rb_i`) and a 64-bit secret (`key_i`). A control-flow protection sequence uses it twice. When a return address is saved, the engine runs in store mode and the caller writes the signature to memory. Before the address is reused, the engine runs in check mode against the value read back, and a mismatch is reported so that the core can raise a trap. The memory access itself is left to the surrounding logic.

The operands first pass through a byte interleave that yields two 64-bit words. Each word is split into two 32-bit blocks, and each of the four blocks goes to its own lane of a 16-bit-half Feistel cipher. All lanes share one expanded key schedule, but each lane reads the round keys of every group of four in its own rotated order. The signature is the XOR of the two 64-bit words that the lanes return. One round of all four lanes is computed per clock, and key words are expanded on the fly, one per round.

Top module: `rah_engine`

## Requirements
- R1: The key is split into 16-bit words k0 = key[63:48], k1 = key[47:32], k2 = key[31:16], k3 = key[15:0]. For step s = 0..27, with t = ror16(k[s+3],3) ^ k[s+1], the next word is k[s+4] = 16'hFFFC ^ z ^ k[s] ^ t ^ ror16(t,1), where z is bit (63-s) of 64'hFA2561CDF44AC398.
- R2: Lane n (0..3) uses k[4g + ((j+n) mod 4)] as the key of round 4g+j (g = 0..7, j = 0..3).
- R3: A 32-bit block loads its bits [15:0] as left half A and its bits [31:16] as right half B. Each of the 32 rounds sets A' = B ^ ((rol16(A,1) & rol16(A,8)) ^ rol16(A,2)) ^ key and B' = A. The block result is {B, A}.
- R4: Pre-mix: in word H, byte i of rb_i (i = 0..3) goes to byte position 7-2i and byte 4+i of ra_i goes to byte position 2i. Word L is built the same way from bytes 4..7 of rb_i and bytes 0..3 of ra_i (byte 0 = bits [7:0]).
- R5: H[63:32], H[31:0], L[63:32] and L[31:0] are enciphered by lanes 0, 1, 2 and 3. digest_o = {lane0, lane1} ^ {lane2, lane3}.
- R6: A start_i sampled while idle makes busy_o high from the next cycle for exactly 32 cycles. done_o is high in the cycle after the last busy cycle, which is the 33rd cycle after the start edge.
- R7: done_o lasts a single cycle and is never high together with busy_o.
- R8: digest_o changes only in the cycle in which done_o is high, and holds its value until the next completion.
- R9: In check mode (check_i = 1 at start), mismatch_o is high together with done_o exactly when the digest differs from the cmp_i value sampled at start. It is low in all other cycles.
- R10: In store mode (check_i = 0 at start), mismatch_o stays low whatever cmp_i holds.
- R11: start_i is ignored while busy_o is high. The running operation completes at its original time with its original digest, and no second done_o follows.
- R12: After reset, busy_o, done_o, mismatch_o and digest_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| check_i | input | 1 | 1 = check mode, 0 = store mode; sampled with start |
| ra_i | input | 64 | First operand; sampled with start |
| rb_i | input | 64 | Second operand; sampled with start |
| key_i | input | 64 | Secret key; sampled with start |
| cmp_i | input | 64 | Value to compare in check mode; sampled with start |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle completion pulse |
| digest_o | output | 64 | Signature, held until the next completion |
| mismatch_o | output | 1 | Check failed; valid with done_o |

## Verification
The bench builds the engine with its default of 32 rounds, which is the round count the signature definition requires. At that setting all 28 key-expansion steps and every group boundary of the lane key rotation are exercised, so any error in the schedule, the pre-mix or the fold changes the compared digest. The directed cases use zero, all-ones and sparse operands, keys that differ by one bit, and operands that differ in only one of ra_i or rb_i. Further cases check both modes against matching and non-matching compare values, and a start issued in the middle of a run.

// File: rtl/rah_pkg.sv
package rah_pkg;

    typedef logic [15:0] half_t;

    localparam logic [63:0] ZSEQ   = 64'hFA2561CDF44AC398;
    localparam half_t       KCONST = 16'hFFFC;
    localparam int          NLANES = 4;

    function automatic half_t rotl(input half_t v, input int unsigned s);
        return half_t'((v << s) | (v >> (16 - s)));
    endfunction

    function automatic half_t rotr(input half_t v, input int unsigned s);
        return half_t'((v >> s) | (v << (16 - s)));
    endfunction

    // Nonlinear round function of the Feistel network
    function automatic half_t mix_f(input half_t a);
        return (rotl(a, 1) & rotl(a, 8)) ^ rotl(a, 2);
    endfunction

    // One key-expansion step
    function automatic half_t key_step(input half_t k0, input half_t k1,
                                       input half_t k3, input logic z);
        half_t t;
        t = rotr(k3, 3) ^ k1;
        return KCONST ^ {15'b0, z} ^ k0 ^ t ^ rotr(t, 1);
    endfunction

    // Byte interleave: byte i of odd_src -> slot 7-2i, byte i of even_src -> slot 2i
    function automatic logic [63:0] interleave(input logic [31:0] odd_src,
                                               input logic [31:0] even_src);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            r[8*(7-2*i) +: 8] = odd_src[8*i +: 8];
            r[8*(2*i)   +: 8] = even_src[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/rah_keysched.sv
module rah_keysched
    import rah_pkg::*;
#(
    parameter int ROUNDS = 32,
    localparam int CW    = $clog2(ROUNDS),
    localparam int EXP   = ROUNDS - 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [63:0]             key_i,
    input  logic                    adv_i,
    input  logic [CW-1:0]           step_i,
    output half_t [NLANES-1:0]      rk_o
);

    typedef struct packed {
        half_t [3:0] cur;   // words 4g .. 4g+3 of the active group
        half_t [3:0] nxt;   // words of the following group, filled one per round
    } ks_t;

    ks_t st_q, st_d;

    logic [1:0] j;
    assign j = step_i[1:0];

    // Each lane reads the active group in its own rotated order (R2)
    for (genvar n = 0; n < NLANES; n++) begin : g_rk
        assign rk_o[n] = st_q.cur[2'(j + 2'(n))];
    end

    always_comb begin
        half_t w0, w1, w3, nw;
        logic  z;
        st_d = st_q;
        w0   = st_q.cur[j];
        w1   = (j == 2'd3) ? st_q.nxt[0] : st_q.cur[2'(j + 2'd1)];
        w3   = (j == 2'd0) ? st_q.cur[3] : st_q.nxt[2'(j - 2'd1)];
        z    = (step_i < CW'(EXP)) ? ZSEQ[6'd63 - 6'(step_i)] : 1'b0;
        nw   = key_step(w0, w1, w3, z);
        if (load_i) begin
            for (int i = 0; i < 4; i++) begin
                st_d.cur[i] = key_i[63-16*i -: 16];
            end
            st_d.nxt = '0;
        end else if (adv_i) begin
            st_d.nxt[j] = nw;
            if (j == 2'd3) begin
                st_d.cur = {nw, st_q.nxt[2], st_q.nxt[1], st_q.nxt[0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a load and a round are never requested in the same cycle
    p_load_adv_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && adv_i));

endmodule

// File: rtl/rah_lane.sv
module rah_lane
    import rah_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [31:0] blk_i,
    input  logic        adv_i,
    input  half_t       rk_i,
    output logic [31:0] rnd_o     // {B, A} after applying the current round
);

    typedef struct packed {
        half_t a;   // left half
        half_t b;   // right half
    } lane_t;

    lane_t st_q, st_d, rnd;

    always_comb begin
        rnd.a = st_q.b ^ mix_f(st_q.a) ^ rk_i;
        rnd.b = st_q.a;
        st_d  = st_q;
        if (load_i) begin
            st_d.a = blk_i[15:0];
            st_d.b = blk_i[31:16];
        end else if (adv_i) begin
            st_d = rnd;
        end
    end

    assign rnd_o = {rnd.b, rnd.a};

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the old left half moves to the right half on every round
    p_half_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && !load_i |=> st_q.b == $past(st_q.a));

endmodule

// File: rtl/rah_engine.sv
module rah_engine
    import rah_pkg::*;
#(
    parameter int ROUNDS = 32,
    localparam int CW    = $clog2(ROUNDS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        check_i,
    input  logic [63:0] ra_i,
    input  logic [63:0] rb_i,
    input  logic [63:0] key_i,
    input  logic [63:0] cmp_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [63:0] digest_o,
    output logic        mismatch_o
);

    localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          mism;
        logic          check;
        logic [CW-1:0] cnt;
        logic [63:0]   cmp;
        logic [63:0]   digest;
    } ctl_t;

    ctl_t st_q, st_d;

    logic                    load, adv;
    logic [63:0]             pre_h, pre_l, fold;
    logic [NLANES-1:0][31:0] lane_in, lane_out;
    half_t [NLANES-1:0]      rk;

    assign load = start_i && !st_q.busy;   // R11: start ignored while busy
    assign adv  = st_q.busy;

    // R4: byte interleave pre-mix
    assign pre_h = interleave(rb_i[31:0],  ra_i[63:32]);
    assign pre_l = interleave(rb_i[63:32], ra_i[31:0]);

    // R5: lane input assignment
    assign lane_in[0] = pre_h[63:32];
    assign lane_in[1] = pre_h[31:0];
    assign lane_in[2] = pre_l[63:32];
    assign lane_in[3] = pre_l[31:0];

    rah_keysched #(.ROUNDS(ROUNDS)) u_ks (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .key_i  (key_i),
        .adv_i  (adv),
        .step_i (st_q.cnt),
        .rk_o   (rk)
    );

    for (genvar n = 0; n < NLANES; n++) begin : g_lane
        rah_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .blk_i  (lane_in[n]),
            .adv_i  (adv),
            .rk_i   (rk[n]),
            .rnd_o  (lane_out[n])
        );
    end

    assign fold = {lane_out[0], lane_out[1]} ^ {lane_out[2], lane_out[3]};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.mism = 1'b0;
        if (load) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = '0;
            st_d.check = check_i;
            st_d.cmp   = cmp_i;
        end else if (st_q.busy) begin
            if (st_q.cnt == LAST) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.digest = fold;
                st_d.mism   = st_q.check && (fold != st_q.cmp);
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o     = st_q.busy;
    assign done_o     = st_q.done;
    assign digest_o   = st_q.digest;
    assign mismatch_o = st_q.mism;

    // R6: an accepted start makes the engine busy next cycle
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o && !done_o);

    // R7: done is a single-cycle pulse, never with busy
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    // R8: digest moves only when done is raised
    p_digest_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(digest_o));

    // R9: mismatch only accompanies done
    p_mism_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> done_o);

    // R10: store mode never reports a mismatch
    p_store_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !st_q.check |=> !mismatch_o);

    // R11: a running operation keeps counting regardless of start
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && st_q.cnt != LAST |=> busy_o && st_q.cnt == $past(st_q.cnt) + 1'b1);

endmodule

// File: tb/rah_engine_bench.sv
module rah_engine_bench;

    localparam int          PERIOD = 10;
    localparam logic [63:0] ZREF   = 64'hFA2561CDF44AC398;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        check_i = 1'b0;
    logic [63:0] ra_i = '0, rb_i = '0, key_i = '0, cmp_i = '0;
    logic        busy_o, done_o, mismatch_o;
    logic [63:0] digest_o;

    int total = 0;
    int bad   = 0;

    always #(PERIOD/2) clk = ~clk;

    rah_engine u_rah_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .check_i(check_i),
        .ra_i(ra_i), .rb_i(rb_i), .key_i(key_i), .cmp_i(cmp_i),
        .busy_o(busy_o), .done_o(done_o), .digest_o(digest_o),
        .mismatch_o(mismatch_o)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic logic [15:0] rr(input logic [15:0] v, input int s);
        logic [31:0] d;
        d = {v, v} >> s;
        return d[15:0];
    endfunction

    function automatic logic [15:0] rl(input logic [15:0] v, input int s);
        return rr(v, 16 - s);
    endfunction

    function automatic logic [31:0] ref_block(input logic [31:0] x,
                                              input logic [63:0] key,
                                              input int lane);
        logic [15:0] w [36];
        logic [15:0] a, b, t, f, tmp, kk;
        for (int i = 0; i < 4; i++) w[i] = key[63-16*i -: 16];
        for (int s = 0; s < 28; s++) begin
            t = rr(w[s+3], 3) ^ w[s+1];
            w[s+4] = 16'hFFFC ^ {15'b0, ZREF[63-s]} ^ w[s] ^ t ^ rr(t, 1);
        end
        a = x[15:0];
        b = x[31:16];
        for (int r = 0; r < 32; r++) begin
            kk  = w[4*(r/4) + ((r%4 + lane) % 4)];
            f   = (rl(a, 1) & rl(a, 8)) ^ rl(a, 2);
            tmp = a;
            a   = b ^ f ^ kk;
            b   = tmp;
        end
        return {b, a};
    endfunction

    function automatic logic [63:0] ref_digest(input logic [63:0] ra,
                                               input logic [63:0] rb,
                                               input logic [63:0] key);
        logic [63:0] h, l;
        h = '0;
        l = '0;
        for (int i = 0; i < 4; i++) begin
            h[8*(7-2*i) +: 8] = rb[8*i +: 8];
            h[16*i +: 8]      = ra[8*(4+i) +: 8];
            l[8*(7-2*i) +: 8] = rb[8*(4+i) +: 8];
            l[16*i +: 8]      = ra[8*i +: 8];
        end
        return {ref_block(h[63:32], key, 0), ref_block(h[31:0], key, 1)} ^
               {ref_block(l[63:32], key, 2), ref_block(l[31:0], key, 3)};
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Launch one operation and follow it to completion; checks R6/R7/R8 timing
    task automatic run_op(input logic chk_mode, input logic [63:0] ra, input logic [63:0] rb,
                          input logic [63:0] key, input logic [63:0] cmp,
                          output logic [63:0] dg, output logic mm);
        int n = 0;
        int busy_cnt = 0;
        logic [63:0] prev_dg;
        prev_dg = digest_o;
        check_i = chk_mode; ra_i = ra; rb_i = rb; key_i = key; cmp_i = cmp;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        chk("R6 busy after start", {63'b0, busy_o}, 64'd1);
        while (!done_o && n < 100) begin
            if (busy_o) busy_cnt++;
            if (digest_o !== prev_dg) chk("R8 digest held while running", digest_o, prev_dg);
            @(negedge clk);
            n++;
        end
        chk("R6 done cycle", 64'(n), 64'd33);
        chk("R6 busy length", 64'(busy_cnt), 64'd32);
        chk("R7 busy low with done", {63'b0, busy_o}, 64'd0);
        dg = digest_o;
        mm = mismatch_o;
        @(negedge clk);
        chk("R7 done single cycle", {63'b0, done_o}, 64'd0);
        chk("R9 mismatch only with done", {63'b0, mismatch_o}, 64'd0);
        chk("R8 digest held after done", digest_o, dg);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R12 busy reset", {63'b0, busy_o}, 64'd0);
        chk("R12 done reset", {63'b0, done_o}, 64'd0);
        chk("R12 mismatch reset", {63'b0, mismatch_o}, 64'd0);
        chk("R12 digest reset", digest_o, 64'd0);
    endtask

    task automatic t_store(input string req, input logic [63:0] ra, input logic [63:0] rb,
                           input logic [63:0] key);
        logic [63:0] dg;
        logic mm;
        run_op(1'b0, ra, rb, key, ~ref_digest(ra, rb, key), dg, mm);
        chk(req, dg, ref_digest(ra, rb, key));
        chk("R10 store mode no mismatch", {63'b0, mm}, 64'd0);
    endtask

    task automatic t_check(input logic [63:0] ra, input logic [63:0] rb, input logic [63:0] key);
        logic [63:0] dg, exp;
        logic mm;
        exp = ref_digest(ra, rb, key);
        run_op(1'b1, ra, rb, key, exp, dg, mm);
        chk("R9 check equal digest", dg, exp);
        chk("R9 equal gives no mismatch", {63'b0, mm}, 64'd0);
        run_op(1'b1, ra, rb, key, exp ^ 64'h1, dg, mm);
        chk("R9 differing value flags mismatch", {63'b0, mm}, 64'd1);
        run_op(1'b1, ra, rb, key, exp ^ 64'h8000_0000_0000_0000, dg, mm);
        chk("R9 top-bit difference flags mismatch", {63'b0, mm}, 64'd1);
    endtask

    task automatic t_busy_start();
        logic [63:0] ra, rb, key, exp;
        int n;
        int dones = 0;
        ra  = 64'h0123_4567_89AB_CDEF;
        rb  = 64'hFEDC_BA98_7654_3210;
        key = 64'h1F2E_3D4C_5B6A_7988;
        exp = ref_digest(ra, rb, key);
        check_i = 1'b0; ra_i = ra; rb_i = rb; key_i = key; cmp_i = '0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        repeat (4) begin @(negedge clk); n++; end
        ra_i = ~ra; rb_i = 64'h55; key_i = ~key; check_i = 1'b1; cmp_i = 64'h1;
        start_i = 1'b1;
        @(negedge clk);
        n++;
        start_i = 1'b0;
        while (!done_o && n < 100) begin @(negedge clk); n++; end
        chk("R11 original done time", 64'(n), 64'd33);
        chk("R11 original digest kept", digest_o, exp);
        chk("R11 original mode kept", {63'b0, mismatch_o}, 64'd0);
        repeat (40) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        chk("R11 no second completion", 64'(dones), 64'd0);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store("R1 R3 R5 all-zero digest", 64'h0, 64'h0, 64'h0);
        t_store("R1 R2 all-ones digest", '1, '1, '1);
        t_store("R2 R5 key-only digest", 64'h0, 64'h0, 64'h8000_0000_0000_0001);
        t_store("R1 single key bit change", 64'h0, 64'h0, 64'h8000_0000_0000_0000);
        t_store("R4 ra-only operand", 64'h1122_3344_5566_7788, 64'h0, 64'hA5A5_5A5A_0F0F_F0F0);
        t_store("R4 rb-only operand", 64'h0, 64'h99AA_BBCC_DDEE_FF00, 64'hA5A5_5A5A_0F0F_F0F0);
        t_store("R3 R5 mixed operands", 64'hDEAD_BEEF_0000_1000, 64'h0000_7FFF_FFFF_FFF0,
                64'hC0DE_1234_ABCD_0042);
        t_check(64'h0000_0000_1000_2000, 64'h0000_7FFF_0123_4567, 64'h3141_5926_5358_9793);
        t_busy_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule